// File: doc/BRIEF.md
# Configuration Instruction Sequencer

This block steps through a small program memory of 27-bit configuration words, addressed by a 6-bit program counter. It decodes the 4-bit opcode in the top bits of each word. The control-flow opcodes are handled inside the block: stop, unconditional jump, timed stall and conditional branch. Every other opcode is treated as a configuration instruction and sent out on a dispatch bus together with a one-cycle valid strobe.

A configuration instruction may occupy one, two or three consecutive memory words. A two-bit count in its first word says how many further words belong to it. The sequencer fetches them back to back and stacks them into one wide word, with the first word in the most significant position, so the opcode always sits in the top four bits of the dispatched word. The word is released only once its last part has been fetched.

A start pulse launches execution from address 0. Execution ends at a stop instruction. The sequencer then freezes its address, stops reading memory and raises a done flag until the next start pulse. The program memory read port is combinational: the word at `pm_addr` must be present on `pm_data` in the same cycle.

Top module: `cfg_sequencer`

## Requirements
- R1: After reset, `done`, `disp_valid` and `pm_rd_en` are low and `pm_addr` is 0. Nothing is fetched until `start` is pulsed.
- R2: In the cycle after a `start` pulse, the block reads address 0 (`pm_rd_en` high, `pm_addr` = 0), whatever state a previous run left behind.
- R3: Opcode 0 (stop) ends execution. From the next cycle on, `done` is high, `pm_rd_en` and `disp_valid` stay low, and `pm_addr` holds the stop word's address until the next `start`.
- R4: Opcode 6 (jump) makes the next fetch come from the address in bits [22:17] of the jump word.
- R5: Opcode 7 (stall) suppresses fetching for exactly N+1 cycles, where N is bits [21:7]. Fetching then resumes at the following address, so N = 0 gives a one-cycle stall.
- R6: Opcode 11 (branch) sends the next fetch to bits [20:15] when `br_cond` is low, and to the next address when `br_cond` is high. The 2-bit mode in bits [22:21] does not affect the sequencing.
- R7: Any other opcode whose follow count (bits [20:19]) is 0 is dispatched in the cycle after its fetch. The word appears in `disp_word[80:54]`, the lower bits are zero, and `disp_len` is 1.
- R8: A follow count F of 1 or 2 makes the block fetch the next F words as payload, without decoding them. In the cycle after the last of them, it dispatches the F+1 words stacked from the top of `disp_word`, first word highest, with `disp_len` = F+1.
- R9: A follow count of 3 is treated as 2, so an instruction never exceeds three words.
- R10: The address counter wraps from 63 to 0, both between instructions and inside a multi-word instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that starts execution at address 0 |
| br_cond | input | 1 | Branch condition; low selects the branch target |
| pm_addr | output | 6 | Program memory address |
| pm_rd_en | output | 1 | High in cycles whose `pm_data` is consumed |
| pm_data | input | 27 | Program memory word at `pm_addr` |
| disp_valid | output | 1 | One-cycle strobe for a dispatched instruction |
| disp_word | output | 81 | Assembled instruction, first word in bits [80:54] |
| disp_len | output | 2 | Number of words in the dispatched instruction |
| done | output | 1 | High after a stop instruction until the next start |

## Verification
Some rules can be judged from one or two adjacent cycles, and the assertions check these on every cycle: the quiet, frozen state after a stop; the address after a jump or a branch in either polarity; the missing fetch right after a stall begins; and the legal range of `disp_len`. Other behaviours only show up in the bench's end-to-end scenarios. These are the exact length of a long stall, the stacking order of payload words, the fact that payload words that look like stop or jump are not executed, the capping of a follow count of 3, and address wrap in the middle of an instruction. The bench compares every dispatch's content, length and cycle number, and the cycle in which `done` rises, against its own interpretation of the program.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

  localparam int CHUNK_W  = 27;
  localparam int OPC_W    = 4;
  localparam int WAIT_W   = 15;
  localparam int FOLLOW_W = 2;
  localparam int HDR_LO   = 7;   // lowest header bit any decode field uses

  localparam logic [OPC_W-1:0] OPC_STOP   = 4'd0;
  localparam logic [OPC_W-1:0] OPC_JUMP   = 4'd6;
  localparam logic [OPC_W-1:0] OPC_STALL  = 4'd7;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 4'd11;

  typedef enum logic [2:0] {K_DATA, K_STOP, K_JUMP, K_STALL, K_BRANCH} kind_t;
  typedef enum logic [2:0] {S_IDLE, S_RUN, S_STALL, S_GATHER, S_DONE} seq_state_t;

  function automatic logic [OPC_W-1:0] opc_of(input logic [CHUNK_W-1:0] w);
    return w[26:23];
  endfunction

  function automatic logic [5:0] jump_field(input logic [CHUNK_W-1:0] w);
    return w[22:17];
  endfunction

  function automatic logic [5:0] branch_field(input logic [CHUNK_W-1:0] w);
    return w[20:15];
  endfunction

  function automatic logic [WAIT_W-1:0] stall_field(input logic [CHUNK_W-1:0] w);
    return w[21:7];
  endfunction

  // follow count limited so an instruction never exceeds max_chunks words
  function automatic logic [FOLLOW_W-1:0] follow_field(input logic [CHUNK_W-1:0] w,
                                                       input int max_chunks);
    logic [FOLLOW_W-1:0] f;
    f = w[20:19];
    if (int'(f) > max_chunks - 1) return FOLLOW_W'(max_chunks - 1);
    return f;
  endfunction

endpackage

// File: rtl/cseq_decode.sv
module cseq_decode
  import cseq_pkg::*;
#(
  parameter int PC_W       = 6,
  parameter int MAX_CHUNKS = 3
) (
  input  logic [CHUNK_W-1:HDR_LO] hdr,
  output kind_t                   kind,
  output logic [PC_W-1:0]         jump_tgt,
  output logic [PC_W-1:0]         br_tgt,
  output logic [WAIT_W-1:0]       stall_len,
  output logic [FOLLOW_W-1:0]     follow
);

  logic [CHUNK_W-1:0] word;

  always_comb begin
    word      = {hdr, {HDR_LO{1'b0}}};
    jump_tgt  = PC_W'(jump_field(word));
    br_tgt    = PC_W'(branch_field(word));
    stall_len = stall_field(word);
    follow    = follow_field(word, MAX_CHUNKS);
    case (opc_of(word))
      OPC_STOP:   kind = K_STOP;
      OPC_JUMP:   kind = K_JUMP;
      OPC_STALL:  kind = K_STALL;
      OPC_BRANCH: kind = K_BRANCH;
      default:    kind = K_DATA;
    endcase
  end

endmodule

// File: rtl/cseq_assemble.sv
module cseq_assemble
  import cseq_pkg::*;
#(
  parameter int MAX_CHUNKS = 3,
  parameter int LEN_W      = 2,
  parameter int WORD_W     = CHUNK_W * MAX_CHUNKS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take_first,
  input  logic                take_next,
  input  logic [FOLLOW_W-1:0] follow,
  input  logic [CHUNK_W-1:0]  chunk,
  output logic                gather_last,
  output logic                fire,
  output logic                disp_valid,
  output logic [WORD_W-1:0]   disp_word,
  output logic [LEN_W-1:0]    disp_len
);

  logic [WORD_W-1:0] acc, placed;
  logic [LEN_W-1:0]  taken, total;      // words stored so far / words expected
  logic [LEN_W-1:0]  slot, taken_nxt, total_nxt;
  logic              take;

  always_comb begin
    take      = take_first || take_next;
    slot      = take_first ? '0 : taken;
    taken_nxt = slot + LEN_W'(1);
    total_nxt = take_first ? LEN_W'(follow) + LEN_W'(1) : total;
    placed    = take_first ? '0 : acc;
    for (int s = 0; s < MAX_CHUNKS; s++) begin
      if (LEN_W'(s) == slot) placed[WORD_W-1-s*CHUNK_W -: CHUNK_W] = chunk;
    end
    fire        = take && (taken_nxt == total_nxt);
    gather_last = take_next && (taken_nxt == total);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc        <= '0;
      taken      <= '0;
      total      <= '0;
      disp_valid <= 1'b0;
      disp_word  <= '0;
      disp_len   <= '0;
    end else begin
      disp_valid <= fire;
      if (take) begin
        acc   <= placed;
        taken <= taken_nxt;
        total <= total_nxt;
      end
      if (fire) begin
        disp_word <= placed;
        disp_len  <= total_nxt;
      end
    end
  end

endmodule

// File: rtl/cseq_ctrl.sv
module cseq_ctrl
  import cseq_pkg::*;
#(
  parameter int PC_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                br_cond,
  input  logic                gather_last,
  input  kind_t               kind,
  input  logic [PC_W-1:0]     jump_tgt,
  input  logic [PC_W-1:0]     br_tgt,
  input  logic [WAIT_W-1:0]   stall_len,
  input  logic [FOLLOW_W-1:0] follow,
  output logic [PC_W-1:0]     pc,
  output logic                fetch,
  output logic                done,
  output logic                take_first,
  output logic                take_next,
  output logic                ev_stop,
  output logic                ev_jump,
  output logic                ev_stall,
  output logic                ev_branch
);

  seq_state_t        state;
  logic [WAIT_W-1:0] stall_cnt;
  logic [PC_W-1:0]   pc_inc;

  function automatic logic [PC_W-1:0] step_pc(input logic [PC_W-1:0] p);
    return p + PC_W'(1);   // wraps modulo 2**PC_W
  endfunction

  always_comb begin
    pc_inc     = step_pc(pc);
    fetch      = (state == S_RUN) || (state == S_GATHER);
    ev_stop    = (state == S_RUN) && (kind == K_STOP);
    ev_jump    = (state == S_RUN) && (kind == K_JUMP);
    ev_stall   = (state == S_RUN) && (kind == K_STALL);
    ev_branch  = (state == S_RUN) && (kind == K_BRANCH);
    take_first = (state == S_RUN) && (kind == K_DATA);
    take_next  = (state == S_GATHER);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      pc        <= '0;
      done      <= 1'b0;
      stall_cnt <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: begin
          if (start) begin
            state <= S_RUN;
            pc    <= '0;
            done  <= 1'b0;
          end
        end
        S_RUN: begin
          case (kind)
            K_STOP: begin
              state <= S_DONE;
              done  <= 1'b1;
            end
            K_JUMP:   pc <= jump_tgt;
            K_STALL: begin
              stall_cnt <= stall_len;
              state     <= S_STALL;
              pc        <= pc_inc;
            end
            K_BRANCH: pc <= br_cond ? pc_inc : br_tgt;
            default: begin
              pc <= pc_inc;
              if (follow != '0) state <= S_GATHER;
            end
          endcase
        end
        S_STALL: begin
          if (stall_cnt == '0) state <= S_RUN;
          else                 stall_cnt <= stall_cnt - WAIT_W'(1);
        end
        S_GATHER: begin
          pc <= pc_inc;
          if (gather_last) state <= S_RUN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_sequencer.sv
module cfg_sequencer
  import cseq_pkg::*;
#(
  parameter int PC_W       = 6,
  parameter int MAX_CHUNKS = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic                              br_cond,
  output logic [PC_W-1:0]                   pm_addr,
  output logic                              pm_rd_en,
  input  logic [CHUNK_W-1:0]                pm_data,
  output logic                              disp_valid,
  output logic [CHUNK_W*MAX_CHUNKS-1:0]     disp_word,
  output logic [$clog2(MAX_CHUNKS+1)-1:0]   disp_len,
  output logic                              done
);

  localparam int WORD_W = CHUNK_W * MAX_CHUNKS;
  localparam int LEN_W  = $clog2(MAX_CHUNKS + 1);

  kind_t                kind;
  logic [PC_W-1:0]      jump_tgt, br_tgt, pc;
  logic [WAIT_W-1:0]    stall_len;
  logic [FOLLOW_W-1:0]  follow;
  logic                 take_first, take_next, gather_last, fire, fetch;
  logic                 ev_stop, ev_jump, ev_stall, ev_branch;

  cseq_decode #(.PC_W(PC_W), .MAX_CHUNKS(MAX_CHUNKS)) u_decode (
    .hdr       (pm_data[CHUNK_W-1:HDR_LO]),
    .kind      (kind),
    .jump_tgt  (jump_tgt),
    .br_tgt    (br_tgt),
    .stall_len (stall_len),
    .follow    (follow)
  );

  cseq_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .br_cond     (br_cond),
    .gather_last (gather_last),
    .kind        (kind),
    .jump_tgt    (jump_tgt),
    .br_tgt      (br_tgt),
    .stall_len   (stall_len),
    .follow      (follow),
    .pc          (pc),
    .fetch       (fetch),
    .done        (done),
    .take_first  (take_first),
    .take_next   (take_next),
    .ev_stop     (ev_stop),
    .ev_jump     (ev_jump),
    .ev_stall    (ev_stall),
    .ev_branch   (ev_branch)
  );

  cseq_assemble #(.MAX_CHUNKS(MAX_CHUNKS), .LEN_W(LEN_W), .WORD_W(WORD_W)) u_assemble (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_first  (take_first),
    .take_next   (take_next),
    .follow      (follow),
    .chunk       (pm_data),
    .gather_last (gather_last),
    .fire        (fire),
    .disp_valid  (disp_valid),
    .disp_word   (disp_word),
    .disp_len    (disp_len)
  );

  assign pm_addr  = pc;
  assign pm_rd_en = fetch;

endmodule

// File: rtl/cseq_checker.sv
module cseq_checker #(
  parameter int PC_W       = 6,
  parameter int LEN_W      = 2,
  parameter int MAX_CHUNKS = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             br_cond,
  input logic [PC_W-1:0]  pm_addr,
  input logic             pm_rd_en,
  input logic [7:0]       tgt_bits,   // program word bits [22:15]
  input logic             done,
  input logic             disp_valid,
  input logic [LEN_W-1:0] disp_len,
  input logic             ev_stop,
  input logic             ev_jump,
  input logic             ev_stall,
  input logic             ev_branch
);

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!pm_rd_en && !disp_valid)); // R3

  AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pm_addr))); // R3

  AST_STOP_RAISES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> done); // R3

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_jump |=> (pm_addr == PC_W'($past(tgt_bits[7:2])))); // R4

  AST_STALL_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall |=> !pm_rd_en); // R5

  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_branch && !br_cond) |=> (pm_addr == PC_W'($past(tgt_bits[5:0])))); // R6

  AST_BRANCH_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_branch && br_cond) |=> (pm_addr == PC_W'($past(pm_addr) + 1'b1))); // R6

  AST_DISP_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_len != '0 && int'(disp_len) <= MAX_CHUNKS)); // R8

endmodule

bind cfg_sequencer cseq_checker #(
  .PC_W(PC_W), .LEN_W(LEN_W), .MAX_CHUNKS(MAX_CHUNKS)
) u_cseq_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .br_cond    (br_cond),
  .pm_addr    (pm_addr),
  .pm_rd_en   (pm_rd_en),
  .tgt_bits   (pm_data[22:15]),
  .done       (done),
  .disp_valid (disp_valid),
  .disp_len   (disp_len),
  .ev_stop    (ev_stop),
  .ev_jump    (ev_jump),
  .ev_stall   (ev_stall),
  .ev_branch  (ev_branch)
);

// File: tb/test_cfg_sequencer.sv
module test_cfg_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        br_cond = 1'b0;
  logic [5:0]  pm_addr;
  logic        pm_rd_en;
  logic [26:0] pm_data;
  logic        disp_valid;
  logic [80:0] disp_word;
  logic [1:0]  disp_len;
  logic        done;

  logic [26:0] mem [0:63];
  assign pm_data = mem[pm_addr];

  always #10 clk = ~clk;   // 50 MHz

  cfg_sequencer i_cfg_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .br_cond(br_cond),
    .pm_addr(pm_addr), .pm_rd_en(pm_rd_en), .pm_data(pm_data),
    .disp_valid(disp_valid), .disp_word(disp_word), .disp_len(disp_len),
    .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  int tick = 0;

  logic [80:0] e_word [0:63];
  int          e_len  [0:63];
  int          e_cyc  [0:63];
  int          e_n, e_done_cyc, e_stop_pc;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [80:0] act, input logic [80:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    tick++;
    if (tick > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", tick);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // Independent interpreter: expected dispatches and the cycle done rises.
  task automatic build_expect(input bit cond);
    int pc = 0;
    int t = 0;
    e_n = 0; e_done_cyc = -1; e_stop_pc = 0;
    for (int step = 0; step < 2000; step++) begin
      logic [26:0] w;
      int op;
      w = mem[pc];
      op = int'(w[26:23]);
      if (op == 0) begin
        e_done_cyc = t + 1; e_stop_pc = pc; break;
      end else if (op == 6) begin
        pc = int'(w[22:17]); t += 1;
      end else if (op == 7) begin
        t += 2 + int'(w[21:7]); pc = (pc + 1) % 64;
      end else if (op == 11) begin
        pc = cond ? (pc + 1) % 64 : int'(w[20:15]); t += 1;
      end else begin
        int f;
        logic [80:0] acc;
        f = int'(w[20:19]);
        if (f > 2) f = 2;
        acc = '0;
        for (int k = 0; k <= f; k++)
          acc = acc | ({mem[(pc + k) % 64], 54'b0} >> (27 * k));
        e_word[e_n] = acc; e_len[e_n] = f + 1; e_cyc[e_n] = t + f + 1;
        e_n++;
        t += f + 1; pc = (pc + f + 1) % 64;
      end
    end
  endtask

  task automatic run_prog(input bit cond, input string tag);
    int cyc = 0;
    int got = 0;
    bit fin = 0;
    br_cond = cond;
    build_expect(cond);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!fin && cyc < 6000) begin
      if (cyc == 0)
        chk(pm_rd_en && pm_addr == 6'd0 && !done, {tag, " R2"}, "first fetch addr",
            {pm_rd_en, pm_addr}, {1'b1, 6'd0});
      if (disp_valid) begin
        string rq;
        rq = (got < e_n && e_len[got] == 1) ? " R7" : " R8";
        if (got < e_n) begin
          chk(disp_word == e_word[got], {tag, rq}, "dispatched word", disp_word, e_word[got]);
          chk(int'(disp_len) == e_len[got] && cyc == e_cyc[got], {tag, rq}, "len/cycle",
              {disp_len, 32'(cyc)}, {2'(e_len[got]), 32'(e_cyc[got])});
        end else
          chk(1'b0, {tag, rq}, "unexpected dispatch", disp_word, '0);
        got++;
      end
      if (done) begin
        chk(cyc == e_done_cyc, {tag, " R3"}, "done cycle", cyc, e_done_cyc);
        fin = 1;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    if (!fin) chk(1'b0, {tag, " R3"}, "run never finished", cyc, e_done_cyc);
    chk(got == e_n, {tag, " R8"}, "dispatch count", got, e_n);
    repeat (3) @(negedge clk);
    chk(done && !pm_rd_en && !disp_valid && int'(pm_addr) == e_stop_pc, {tag, " R3"},
        "held after stop", {done, pm_rd_en, pm_addr}, {1'b1, 1'b0, 6'(e_stop_pc)});
  endtask

  function automatic logic [26:0] data_word(input int f);
    logic [3:0] ops [0:11];
    logic [26:0] w;
    ops = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd8, 4'd9, 4'd10, 4'd12, 4'd13, 4'd14, 4'd15};
    w = 27'($urandom);
    w[26:23] = ops[$urandom % 12];
    w[20:19] = 2'(f);
    return w;
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 27'd0;   // opcode 0 everywhere
  endtask

  task automatic gen_prog();
    int pos = 0;
    clear_mem();
    while (pos < 48) begin
      int r;
      r = int'($urandom % 10);
      if (r < 5) begin
        int f, fl;
        f = int'($urandom % 4);
        fl = (f > 2) ? 2 : f;
        mem[pos] = data_word(f);
        for (int k = 1; k <= fl; k++) mem[pos + k] = 27'($urandom);
        pos += fl + 1;
      end else if (r < 7) begin
        mem[pos] = {4'd7, 1'b0, 15'($urandom % 6), 7'($urandom)};
        pos++;
      end else if (r == 7) begin
        int k;
        k = int'($urandom % 3);
        mem[pos] = {4'd6, 6'(pos + 1 + k), 17'($urandom)};
        pos += 1 + k;
      end else begin
        mem[pos] = {4'd11, 2'($urandom), 6'(pos + 2), 15'($urandom)};
        mem[pos + 1] = data_word(0);
        pos += 2;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!done && !disp_valid && !pm_rd_en && pm_addr == 6'd0, "R1", "reset outputs",
        {done, disp_valid, pm_rd_en, pm_addr}, '0);
    repeat (4) @(negedge clk);
    chk(!pm_rd_en && !done, "R2", "idle without start", {pm_rd_en, done}, '0);

    // R5: zero stall is one cycle, then a one-word dispatch (R7)
    clear_mem();
    mem[0] = {4'd7, 1'b0, 15'd0, 7'h55};
    mem[1] = data_word(0);
    run_prog(1'b0, "R5 stall0");

    // R5: long stall
    clear_mem();
    mem[0] = data_word(0);
    mem[1] = {4'd7, 1'b1, 15'd300, 7'h0};
    mem[2] = data_word(1);
    mem[3] = 27'h7ffffff;
    run_prog(1'b0, "R5 stall300");

    // R8: payload words that look like stop and jump are not executed
    clear_mem();
    mem[0] = data_word(2);
    mem[1] = 27'h0000123;
    mem[2] = {4'd6, 6'd40, 17'h0};
    run_prog(1'b0, "R8 payload");

    // R9: follow count of 3 capped at two extra words
    clear_mem();
    mem[0] = data_word(3);
    mem[1] = 27'h1234567;
    mem[2] = 27'h2abcdef;
    mem[3] = data_word(0);
    run_prog(1'b0, "R9 cap");

    // R10 with R4: jump to 62, three-word instruction wraps through 63 and 0
    clear_mem();
    mem[0]  = {4'd6, 6'd62, 17'h1};
    mem[62] = data_word(2);
    mem[63] = 27'h3000001;
    run_prog(1'b0, "R10 wrap");

    // R6: branch in both polarities, mode bits set
    clear_mem();
    mem[0] = {4'd11, 2'b11, 6'd5, 15'h7fff};
    mem[1] = data_word(0);
    mem[5] = data_word(1);
    mem[6] = 27'h15;
    run_prog(1'b0, "R6 taken");
    run_prog(1'b1, "R6 fallthru");

    // randomized programs, mixed with R4 jumps and R6 branches
    for (int p = 0; p < 24; p++) begin
      gen_prog();
      run_prog(p[0], "Rnd");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule